// File: doc/BRIEF.md
# Cascaded UART Baud Clock Generator

This block derives the timing pulses that a UART needs from one of several base clocks. It produces a one-cycle sample tick at the oversampling rate and a one-cycle bit strobe once per serial bit. The base clocks arrive as clock-enable inputs running on the block's own clock. A reference enable stands in for the crystal clock, and four further enables are the selectable sources. The chosen enable stream passes through a first prescaler, then a second prescaler, each dividing by 1 to 6. A 10-bit main divider follows and produces the sample tick. An oversampling counter then groups ticks into bits, using either a programmed count of up to 63 or the default of 16.

Software programs two 32-bit words through a small write port: a rate word and an oversampling word. Writes land in shadow registers. The shadows are copied into the active configuration, and every counter restarts, on the first cycle in which the transmitter reports idle. A rate change therefore never cuts a character that is being sent. The resulting bit rate is the base enable rate divided by d1, d2, the divider and the oversampling count.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset the active configuration uses the reference enable, with both prescalers and the divider at 1 and 16 ticks per bit. With the reference enable held high, a tick appears every cycle and a strobe appears every 16 ticks. Both outputs are low while reset is applied.
- R2: Rate word bits [9:0] set the main divider. A tick is issued once per that many prescaled pulses, and a value of 0 behaves as 1.
- R3: Rate word bits [17:15] set prescaler d1 and bits [14:12] set prescaler d2. The tick period is multiplied by d1*d2. A value of 0 behaves as 1, and values 7 and above behave as 6.
- R4: When rate word bit 19 is 1, bits [11:10] pick which of the four source enables drives the chain. When bit 19 is 0, the reference enable drives it and bits [11:10] have no effect.
- R5: Oversampling word bits [5:0] give the ticks per bit. A value of 0 means 16. Bits [7:6] and bits [31:8] are ignored.
- R6: A write with cfg_sel=0 targets the rate word and cfg_sel=1 targets the oversampling word. A written value takes effect only on the first cycle that tx_idle is high. Until then the previous rate stays in force.
- R7: bit_strobe is asserted only together with sample_tick, once every N ticks, where N is the effective oversampling count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_sel | input | 1 | 0 = rate word, 1 = oversampling word |
| cfg_wdata | input | 32 | Write data |
| tx_idle | input | 1 | Transmitter empty; allows pending settings to be applied |
| ref_en | input | 1 | Reference clock enable |
| src_en | input | 4 | Selectable base clock enables |
| sample_tick | output | 1 | One-cycle pulse per oversampling sample |
| bit_strobe | output | 1 | One-cycle pulse per serial bit |

## Verification
A prescaler or divider counter holding a wrong limit or a stale count shows up as a tick interval that differs from d1*d2*div enables. That difference is visible within the second tick after the settings are applied. A wrong source decode either multiplies the interval by the ratio between enable rates or stops ticks entirely, and a silence test catches the latter within a bounded wait. A faulty oversampling counter changes the number of ticks between two strobes, and so shows by the second strobe. A shadow copied while the transmitter is busy changes the tick interval before tx_idle rises.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;

  localparam int DIV_W  = 10;
  localparam int PRE_W  = 3;
  localparam int OS_W   = 6;
  localparam int SRC_N  = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int PRE_MAX = 6;
  localparam int OS_DEFAULT = 16;

  typedef struct packed {
    logic             use_src;
    logic [SEL_W-1:0] src;
    logic [PRE_W-1:0] d1;
    logic [PRE_W-1:0] d2;
    logic [DIV_W-1:0] div;
  } rate_cfg_t;

  localparam rate_cfg_t RATE_RESET = '{use_src: 1'b0, src: '0, d1: 3'd1,
                                       d2: 3'd1, div: 10'd1};

  function automatic rate_cfg_t unpack_rate(input logic [31:0] w);
    rate_cfg_t r;
    r.div     = w[9:0];
    r.src     = w[11:10];
    r.d2      = w[14:12];
    r.d1      = w[17:15];
    r.use_src = w[19];
    return r;
  endfunction

  function automatic logic [DIV_W-1:0] pre_limit(input logic [PRE_W-1:0] v);
    logic [DIV_W-1:0] l;
    if (v == '0)                   l = DIV_W'(1);
    else if (int'(v) > PRE_MAX)    l = DIV_W'(PRE_MAX);
    else                           l = DIV_W'(v);
    return l;
  endfunction

  function automatic logic [DIV_W-1:0] div_limit(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  function automatic logic [OS_W-1:0] os_limit(input logic [OS_W-1:0] v);
    return (v == '0) ? OS_W'(OS_DEFAULT) : v;
  endfunction

endpackage

// File: rtl/uart_rate_cfg.sv
module uart_rate_cfg
  import uart_rate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [31:0]     cfg_wdata,
  input  logic            tx_idle,
  output rate_cfg_t       act_rate,
  output logic [OS_W-1:0] act_os,
  output logic            apply_now
);

  rate_cfg_t       shd_rate;
  logic [OS_W-1:0] shd_os;
  logic            pending;

  assign apply_now = pending && tx_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_rate <= RATE_RESET;
      shd_os   <= '0;
      pending  <= 1'b0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel) shd_os   <= cfg_wdata[OS_W-1:0];
        else         shd_rate <= unpack_rate(cfg_wdata);
      end
      if (cfg_we)         pending <= 1'b1;
      else if (apply_now) pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_rate <= RATE_RESET;
      act_os   <= '0;
    end else if (apply_now) begin
      act_rate <= shd_rate;
      act_os   <= shd_os;
    end
  end

  // R6: the active settings move only after a cycle with the transmitter idle
  p_apply_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_rate) || !$stable(act_os)) |-> $past(tx_idle));

endmodule

// File: rtl/uart_rate_stage.sv
module uart_rate_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         in_pulse,
  input  logic [W-1:0] limit,
  output logic         out_pulse,
  output logic [W-1:0] count
);

  logic at_end;

  assign at_end    = (count == limit - W'(1));
  assign out_pulse = in_pulse && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (restart)        count <= '0;
    else if (in_pulse)       count <= at_end ? '0 : count + W'(1);
  end

  // R2/R3: a stage counter never reaches its own limit
  p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (count < limit));

endmodule

// File: rtl/uart_rate_os.sv
module uart_rate_os
  import uart_rate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick_in,
  input  logic [OS_W-1:0] n_ticks,
  output logic            bit_done
);

  logic [OS_W-1:0] tcnt;
  logic            last;

  assign last     = (tcnt == n_ticks - OS_W'(1));
  assign bit_done = tick_in && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tcnt <= '0;
    else if (restart)  tcnt <= '0;
    else if (tick_in)  tcnt <= last ? '0 : tcnt + OS_W'(1);
  end

  // R5: the tick counter stays inside the effective oversampling count
  p_os_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ticks != '0) |-> (tcnt < n_ticks));

endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import uart_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              tx_idle,
  input  logic              ref_en,
  input  logic [SRC_N-1:0]  src_en,
  output logic              sample_tick,
  output logic              bit_strobe
);

  localparam int N_STAGE = 3;

  rate_cfg_t        act_rate;
  logic [OS_W-1:0]  act_os;
  logic             apply_now;
  logic             base_en;
  logic [DIV_W-1:0] stage_lim [N_STAGE];
  logic [DIV_W-1:0] stage_cnt [N_STAGE];
  logic [N_STAGE:0] chain;
  logic             tick_next;
  logic             bit_next;

  uart_rate_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tx_idle   (tx_idle),
    .act_rate  (act_rate),
    .act_os    (act_os),
    .apply_now (apply_now)
  );

  assign base_en = act_rate.use_src ? src_en[act_rate.src] : ref_en;

  assign stage_lim[0] = pre_limit(act_rate.d1);
  assign stage_lim[1] = pre_limit(act_rate.d2);
  assign stage_lim[2] = div_limit(act_rate.div);

  assign chain[0] = base_en;

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    uart_rate_stage #(.W(DIV_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (apply_now),
      .in_pulse  (chain[g]),
      .limit     (stage_lim[g]),
      .out_pulse (chain[g+1]),
      .count     (stage_cnt[g])
    );
  end

  assign tick_next = chain[N_STAGE] && !apply_now;

  uart_rate_os u_os (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (apply_now),
    .tick_in  (tick_next),
    .n_ticks  (os_limit(act_os)),
    .bit_done (bit_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_tick <= 1'b0;
      bit_strobe  <= 1'b0;
    end else begin
      sample_tick <= tick_next;
      bit_strobe  <= bit_next;
    end
  end

  // R7: every bit strobe lands on a sample tick
  p_strobe_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> sample_tick);

  // R4: a tick is only produced from a cycle where the chosen source was enabled
  p_tick_from_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> $past(base_en));

  // R3: the second prescaler only advances on a first-prescaler pulse
  p_pre2_follows_pre1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain[1] && !apply_now) |=> $stable(stage_cnt[1]));

endmodule

// File: tb/uart_rate_gen_test.sv
module uart_rate_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tx_idle = 1'b1;
  logic        ref_en = 1'b1;
  logic [3:0]  src_en;
  logic        sample_tick, bit_strobe;
  logic [7:0]  ph = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) ph <= ph + 8'd1;
  assign src_en = {(ph[1:0] == 2'b00), ph[0], 1'b0, 1'b1};

  uart_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tx_idle(tx_idle), .ref_en(ref_en),
    .src_en(src_en), .sample_tick(sample_tick), .bit_strobe(bit_strobe)
  );

  function automatic logic [31:0] rate_word(input bit use_src, input int src,
                                            input int d1, input int d2, input int dv);
    return (32'(use_src) << 19) | (32'(d1) << 15) | (32'(d2) << 12) |
           (32'(src) << 10) | 32'(dv);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic write_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_tick(input int limit, output int cyc, output bit to);
    cyc = 0; to = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (sample_tick) break;
      if (cyc >= limit) begin to = 1'b1; break; end
    end
  endtask

  task automatic period(output int p);
    int c; bit to;
    wait_tick(5000, c, to);
    wait_tick(5000, c, to);
    p = to ? -1 : c;
  endtask

  task automatic strobe_ratio(output int n);
    int ticks;
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!bit_strobe && guard < 5000);
    ticks = 0;
    do begin
      @(negedge clk); guard++;
      if (sample_tick) ticks++;
    end while (!bit_strobe && guard < 10000);
    n = ticks;
  endtask

  task automatic t_reset;
    int p, n;
    check("R1 tick low in reset", int'(sample_tick), 0);
    check("R1 strobe low in reset", int'(bit_strobe), 0);
    @(negedge clk); rst_n = 1'b1;
    period(p);       check("R1 reset tick period", p, 1);
    strobe_ratio(n); check("R1 reset ticks per bit", n, 16);
  endtask

  task automatic t_divider;
    int p;
    write_reg(1'b0, rate_word(0, 0, 1, 1, 5));    period(p); check("R2 div 5", p, 5);
    write_reg(1'b0, rate_word(0, 0, 1, 1, 0));    period(p); check("R2 div 0 as 1", p, 1);
    write_reg(1'b0, rate_word(0, 0, 1, 1, 1023)); period(p); check("R2 div 1023", p, 1023);
  endtask

  task automatic t_prescale;
    int p;
    write_reg(1'b0, rate_word(0, 0, 3, 2, 4)); period(p); check("R3 d1=3 d2=2 div=4", p, 24);
    write_reg(1'b0, rate_word(0, 0, 7, 0, 2)); period(p); check("R3 d1=7 clamp, d2=0", p, 12);
    write_reg(1'b0, rate_word(0, 0, 0, 6, 1)); period(p); check("R3 d1=0 d2=6", p, 6);
  endtask

  task automatic t_source;
    int p, c; bit to;
    write_reg(1'b0, rate_word(1, 0, 1, 1, 3)); period(p); check("R4 source 0", p, 3);
    write_reg(1'b0, rate_word(1, 2, 1, 1, 3)); period(p); check("R4 source 2 half rate", p, 6);
    write_reg(1'b0, rate_word(1, 3, 1, 1, 3)); period(p); check("R4 source 3 quarter rate", p, 12);
    write_reg(1'b0, rate_word(1, 1, 1, 1, 3));
    wait_tick(300, c, to);
    check("R4 silent source gives no tick", int'(to), 1);
    write_reg(1'b0, rate_word(0, 3, 1, 1, 3)); period(p); check("R4 bit19 clear uses reference", p, 3);
  endtask

  task automatic t_oversample;
    int n;
    write_reg(1'b0, rate_word(0, 0, 1, 1, 1));
    write_reg(1'b1, 32'h0000_003F); strobe_ratio(n); check("R5 R7 63 ticks per bit", n, 63);
    write_reg(1'b1, 32'h0000_0005); strobe_ratio(n); check("R7 5 ticks per bit", n, 5);
    write_reg(1'b1, 32'h2A2A_2A00); strobe_ratio(n); check("R5 zero field means 16", n, 16);
    write_reg(1'b1, 32'h0000_00C7); strobe_ratio(n); check("R5 bits 7:6 ignored", n, 7);
  endtask

  task automatic t_idle;
    int p, n;
    write_reg(1'b0, rate_word(0, 0, 1, 1, 3));
    period(p); check("R6 baseline", p, 3);
    @(negedge clk); tx_idle = 1'b0;
    write_reg(1'b0, rate_word(0, 0, 1, 1, 5));
    write_reg(1'b1, 32'h0000_0004);
    period(p); check("R6 busy keeps old rate", p, 3);
    period(p); check("R6 busy keeps old rate again", p, 3);
    @(negedge clk); tx_idle = 1'b1;
    period(p); check("R6 idle applies new rate", p, 5);
    strobe_ratio(n); check("R6 idle applies new oversampling", n, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_divider;
    t_prescale;
    t_source;
    t_oversample;
    t_idle;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule